// File: doc/BRIEF.md
# Four-Axis Host Register Interface with Interrupt Collection

This block sits between an 8-bit asynchronous microprocessor bus and four counter axes. It decodes register reads and writes from an active-low chip select, read strobe and write strobe, together with a 3-bit register select and a 2-bit axis select. It keeps each axis's two mode bytes and its 24-bit preset value. A read of an axis's status byte or output-latch bytes returns what the counter core drives into the block.

The read map and the write map share addresses but differ. Address 0 reads a combined interrupt byte, with the mask in the low half and the pending status in the high half, and it writes only the mask. Address 7 is a write-only command register. Each of its bits fires a one-cycle operation on the selected axis, and bit 7 clears that axis's pending interrupt. A pending bit is caught on a high-to-low transition of an axis's flag line while that axis is unmasked. The shared active-low interrupt output is low while any pending bit is set.

The bidirectional data bus is split into data-in, data-out and output-enable. The write strobe is brought into the clock domain through a synchroniser. A write takes effect once, on the detected rising edge of the strobe. Address and data must stay stable until three clock edges after that rising edge.

Top module: `qc_host_regif`

## Requirements
- R1: After reset all mode bytes, preset values, the mask and the pending status are zero, the interrupt output is high, no command pulse is active and the bus is not driven.
- R2: The data-out enable is high only while chip select and read strobe are both low; otherwise data-out is 0x00.
- R3: Reads return, for the selected axis: select 1 mode byte 0, select 2 mode byte 1, select 3 the core's status byte, selects 4/5/6 output-latch bits 7:0/15:8/23:16, and select 7 returns 0x00.
- R4: A read at select 0 returns the mask in bits 3:0 and the pending status in bits 7:4, bit n standing for axis n.
- R5: Writes at select 1 and 2 load mode byte 0 and 1; writes at select 4/5/6 load preset bits 7:0/15:8/23:16. Only the selected axis changes. A write at select 3 changes nothing.
- R6: A write at select 0 loads data bits 3:0 into the mask; data bits 7:4 are ignored.
- R7: A write takes effect at the third clock edge after the write strobe rises and not before. A strobe with chip select high writes nothing.
- R8: A command write (select 7) gives exactly one single-cycle pulse on the selected axis only, for each set data bit: bit0 counter clear, bit1 counter load, bit2 latch snapshot, bit3 status clear, bit4 axis reset, bit5 sign set, bit6 sign clear.
- R9: Command bit 4 also clears the selected axis's mode bytes and preset, plus the whole mask and pending status.
- R10: Command bit 7 clears the pending bit of the selected axis only.
- R11: A pending bit sets, and stays set, one clock after its axis's flag input falls from 1 to 0, but only if that axis's mask bit is 1.
- R12: The interrupt output is low exactly while at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, write on rising edge |
| reg_sel | input | 3 | Register select |
| axis_sel | input | 2 | Axis select |
| dbus_in | input | 8 | Bus write data |
| dbus_out | output | 8 | Bus read data |
| dbus_oe | output | 1 | Bus drive enable |
| axis_stat_i | input | 32 | Status byte of each axis from the counter cores |
| axis_latch_i | input | 96 | 24-bit output latch of each axis |
| flag_a_n_i | input | 4 | Active-low flag of each axis |
| mode0_o | output | 32 | Mode byte 0 of each axis |
| mode1_o | output | 32 | Mode byte 1 of each axis |
| preset_o | output | 96 | 24-bit preset of each axis |
| cnt_clear_o | output | 4 | Counter clear pulse per axis |
| cnt_load_o | output | 4 | Counter load-from-preset pulse per axis |
| latch_snap_o | output | 4 | Counter snapshot pulse per axis |
| stat_clear_o | output | 4 | Sticky status clear pulse per axis |
| axis_reset_o | output | 4 | Axis master reset pulse |
| sign_set_o | output | 4 | Sign set pulse per axis |
| sign_clear_o | output | 4 | Sign clear pulse per axis |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
The bench builds the block with its defaults: four axes, an 8-bit bus, 24-bit counts and a two-stage synchroniser. With these values every axis select code is used, and the interrupt byte fills both nibbles. The preset and latch span all three byte selects. Because four axes exist, the bench can show that pulses, resets and interrupt clears stay on the selected axis while the others hold their values. The two-stage synchroniser fixes the third-edge commit point that the strobe timing test probes.

// File: rtl/qc_regif_pkg.sv
// Shared register-select codes and command bit positions for the
// four-axis host register interface.
package qc_regif_pkg;
    typedef logic [2:0] regsel_t;

    // register select codes (read and write maps share them)
    localparam regsel_t SEL_IRQ   = 3'd0;
    localparam regsel_t SEL_MODE0 = 3'd1;
    localparam regsel_t SEL_MODE1 = 3'd2;
    localparam regsel_t SEL_STAT  = 3'd3;
    localparam regsel_t SEL_BYTE0 = 3'd4;
    localparam regsel_t SEL_BYTE1 = 3'd5;
    localparam regsel_t SEL_BYTE2 = 3'd6;
    localparam regsel_t SEL_CMD   = 3'd7;

    // command register bit positions
    localparam int CMD_CNT_CLR  = 0;
    localparam int CMD_CNT_LOAD = 1;
    localparam int CMD_SNAP     = 2;
    localparam int CMD_STAT_CLR = 3;
    localparam int CMD_AXIS_RST = 4;
    localparam int CMD_SIGN_SET = 5;
    localparam int CMD_SIGN_CLR = 6;
    localparam int CMD_IRQ_CLR  = 7;
endpackage

// File: rtl/qc_wr_sync.sv
// Write strobe synchroniser and rising-edge detector.
// Assumes cs_n and wr_n are asynchronous to clk and that wr_n stays high for at
// least SYNC_STAGES+1 clocks between writes. wr_fire is high for one cycle, the
// cycle after the rising strobe reaches the last synchroniser stage, and only
// if chip select was low alongside the final low strobe sample.
module qc_wr_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic wr_fire
);
    localparam int TOP = SYNC_STAGES;

    logic [TOP:0] wr_pipe;
    logic [TOP:0] cs_pipe;

    // shift strobes through the synchroniser plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pipe <= '1;
            cs_pipe <= '1;
        end else begin
            wr_pipe <= {wr_pipe[TOP-1:0], wr_n};
            cs_pipe <= {cs_pipe[TOP-1:0], cs_n};
        end
    end

    assign wr_fire = wr_pipe[TOP-1] & ~wr_pipe[TOP] & ~cs_pipe[TOP];

    // R7
    wr_fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);
endmodule

// File: rtl/qc_axis_cfg.sv
// Per-axis configuration storage: two mode bytes and a multi-byte preset.
// Writes land on wr_fire for the selected axis; an axis reset pulse clears
// that axis's storage. Assumes reset pulses never coincide with wr_fire.
module qc_axis_cfg
    import qc_regif_pkg::*;
#(
    parameter int NAXES = 4,
    parameter int DW    = 8,
    parameter int CNTW  = 24
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_fire,
    input  regsel_t                              reg_sel,
    input  logic [$clog2(NAXES)-1:0]             axis_sel,
    input  logic [DW-1:0]                        din,
    input  logic [NAXES-1:0]                     axis_rst,
    output logic [NAXES-1:0][DW-1:0]             mode0_q,
    output logic [NAXES-1:0][DW-1:0]             mode1_q,
    output logic [NAXES-1:0][CNTW/DW-1:0][DW-1:0] preset_q
);
    localparam int AXW    = $clog2(NAXES);
    localparam int NBYTES = CNTW / DW;

    for (genvar a = 0; a < NAXES; a++) begin : g_axis
        localparam logic [AXW-1:0] AIDX = AXW'(a);
        logic hit;
        assign hit = wr_fire && (axis_sel == AIDX);

        // mode byte storage for this axis
        always_ff @(posedge clk) begin
            if (!rst_n || axis_rst[a]) begin
                mode0_q[a] <= '0;
                mode1_q[a] <= '0;
            end else if (hit) begin
                if (reg_sel == SEL_MODE0) mode0_q[a] <= din;
                if (reg_sel == SEL_MODE1) mode1_q[a] <= din;
            end
        end

        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            localparam regsel_t BSEL = 3'(32'(SEL_BYTE0) + b);
            // one preset byte of this axis
            always_ff @(posedge clk) begin
                if (!rst_n || axis_rst[a])
                    preset_q[a][b] <= '0;
                else if (hit && reg_sel == BSEL)
                    preset_q[a][b] <= din;
            end
        end
    end

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_fire) && !$past(|axis_rst)) |-> ($stable(mode0_q) && $stable(mode1_q) && $stable(preset_q)));
endmodule

// File: rtl/qc_cmd_pulse.sv
// Command register decode: a command write turns each set data bit into a
// one-cycle registered pulse for the selected axis. The register holds no
// state beyond the pulse itself.
module qc_cmd_pulse
    import qc_regif_pkg::*;
#(
    parameter int NAXES = 4,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_fire,
    input  regsel_t                      reg_sel,
    input  logic [$clog2(NAXES)-1:0]     axis_sel,
    input  logic [DW-1:0]                din,
    output logic [DW-1:0][NAXES-1:0]     pulse_q
);
    localparam int AXW = $clog2(NAXES);

    logic cmd_hit;
    assign cmd_hit = wr_fire && (reg_sel == SEL_CMD);

    for (genvar a = 0; a < NAXES; a++) begin : g_axis
        localparam logic [AXW-1:0] AIDX = AXW'(a);
        for (genvar b = 0; b < DW; b++) begin : g_bit
            // single-cycle pulse for command bit b of axis a
            always_ff @(posedge clk) begin
                if (!rst_n) pulse_q[b][a] <= 1'b0;
                else        pulse_q[b][a] <= cmd_hit && (axis_sel == AIDX) && din[b];
            end
        end
    end

    for (genvar b = 0; b < DW; b++) begin : g_chk
        // R8
        cmd_one_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(pulse_q[b]));
        // R8
        cmd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|pulse_q[b]) |=> !(|pulse_q[b]));
    end
endmodule

// File: rtl/qc_irq_ctrl.sv
// Interrupt mask and pending status. A pending bit captures a 1->0 transition
// of its axis flag while unmasked; it stays set until a per-axis clear or a
// master reset. Assumes flag inputs are synchronous to clk. A new capture
// wins over a clear in the same cycle; a master reset wins over both.
module qc_irq_ctrl #(
    parameter int NAXES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NAXES-1:0] flag_a_n,
    input  logic             mask_wr,
    input  logic [NAXES-1:0] mask_din,
    input  logic [NAXES-1:0] clr,
    input  logic             mrst,
    output logic [NAXES-1:0] mask_q,
    output logic [NAXES-1:0] status_q,
    output logic             irq_n_o
);
    logic [NAXES-1:0] flag_prev;
    logic [NAXES-1:0] fell;

    // remember last flag level; idle level is high
    always_ff @(posedge clk) begin
        if (!rst_n) flag_prev <= '1;
        else        flag_prev <= flag_a_n;
    end

    assign fell = flag_prev & ~flag_a_n & mask_q;

    // mask and pending status update
    always_ff @(posedge clk) begin
        if (!rst_n || mrst) begin
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            if (mask_wr) mask_q <= mask_din;
            status_q <= (status_q & ~clr) | fell;
        end
    end

    assign irq_n_o = ~|status_q;

    for (genvar i = 0; i < NAXES; i++) begin : g_chk
        // R11
        irq_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[i]) |-> ($past(mask_q[i]) && $past(flag_prev[i]) && !$past(flag_a_n[i])));
    end

    // R9
    irq_mrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> (mask_q == '0 && status_q == '0));
endmodule

// File: rtl/qc_host_regif.sv
// Four-axis host register interface. Decodes an asynchronous 8-bit bus into
// per-axis configuration writes, command pulses and a shared interrupt.
// Reads are combinational from stored or core-supplied state. Assumes reg_sel,
// axis_sel and dbus_in are held stable until three clock edges after wr_n rises.
module qc_host_regif
    import qc_regif_pkg::*;
#(
    parameter int NAXES       = 4,
    parameter int DW          = 8,
    parameter int CNTW        = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      rd_n,
    input  logic                      wr_n,
    input  logic [2:0]                reg_sel,
    input  logic [$clog2(NAXES)-1:0]  axis_sel,
    input  logic [DW-1:0]             dbus_in,
    output logic [DW-1:0]             dbus_out,
    output logic                      dbus_oe,
    input  logic [NAXES*DW-1:0]       axis_stat_i,
    input  logic [NAXES*CNTW-1:0]     axis_latch_i,
    input  logic [NAXES-1:0]          flag_a_n_i,
    output logic [NAXES*DW-1:0]       mode0_o,
    output logic [NAXES*DW-1:0]       mode1_o,
    output logic [NAXES*CNTW-1:0]     preset_o,
    output logic [NAXES-1:0]          cnt_clear_o,
    output logic [NAXES-1:0]          cnt_load_o,
    output logic [NAXES-1:0]          latch_snap_o,
    output logic [NAXES-1:0]          stat_clear_o,
    output logic [NAXES-1:0]          axis_reset_o,
    output logic [NAXES-1:0]          sign_set_o,
    output logic [NAXES-1:0]          sign_clear_o,
    output logic                      irq_n
);
    localparam int NBYTES = CNTW / DW;
    localparam int HALF   = DW / 2;

    logic                               wr_fire;
    logic [NAXES-1:0][DW-1:0]           mode0_w;
    logic [NAXES-1:0][DW-1:0]           mode1_w;
    logic [NAXES-1:0][NBYTES-1:0][DW-1:0] preset_w;
    logic [DW-1:0][NAXES-1:0]           pulse_w;
    logic [NAXES-1:0]                   mask_w;
    logic [NAXES-1:0]                   status_w;
    logic [NAXES-1:0][DW-1:0]           stat_arr;
    logic [NAXES-1:0][NBYTES-1:0][DW-1:0] latch_arr;
    logic [DW-1:0]                      rd_byte;

    qc_wr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_wr_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .wr_fire (wr_fire)
    );

    qc_axis_cfg #(.NAXES(NAXES), .DW(DW), .CNTW(CNTW)) u_axis_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_fire),
        .reg_sel  (reg_sel),
        .axis_sel (axis_sel),
        .din      (dbus_in),
        .axis_rst (pulse_w[CMD_AXIS_RST]),
        .mode0_q  (mode0_w),
        .mode1_q  (mode1_w),
        .preset_q (preset_w)
    );

    qc_cmd_pulse #(.NAXES(NAXES), .DW(DW)) u_cmd_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_fire),
        .reg_sel  (reg_sel),
        .axis_sel (axis_sel),
        .din      (dbus_in),
        .pulse_q  (pulse_w)
    );

    qc_irq_ctrl #(.NAXES(NAXES)) u_irq_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_a_n (flag_a_n_i),
        .mask_wr  (wr_fire && reg_sel == SEL_IRQ),
        .mask_din (dbus_in[NAXES-1:0]),
        .clr      (pulse_w[CMD_IRQ_CLR]),
        .mrst     (|pulse_w[CMD_AXIS_RST]),
        .mask_q   (mask_w),
        .status_q (status_w),
        .irq_n_o  (irq_n)
    );

    assign mode0_o      = mode0_w;
    assign mode1_o      = mode1_w;
    assign preset_o     = preset_w;
    assign cnt_clear_o  = pulse_w[CMD_CNT_CLR];
    assign cnt_load_o   = pulse_w[CMD_CNT_LOAD];
    assign latch_snap_o = pulse_w[CMD_SNAP];
    assign stat_clear_o = pulse_w[CMD_STAT_CLR];
    assign axis_reset_o = pulse_w[CMD_AXIS_RST];
    assign sign_set_o   = pulse_w[CMD_SIGN_SET];
    assign sign_clear_o = pulse_w[CMD_SIGN_CLR];

    assign stat_arr  = axis_stat_i;
    assign latch_arr = axis_latch_i;

    // read map selection for the addressed axis
    always_comb begin
        rd_byte = '0;
        case (reg_sel)
            SEL_IRQ: begin
                rd_byte[NAXES-1:0]     = mask_w;
                rd_byte[HALF+:NAXES]   = status_w;
            end
            SEL_MODE0: rd_byte = mode0_w[axis_sel];
            SEL_MODE1: rd_byte = mode1_w[axis_sel];
            SEL_STAT:  rd_byte = stat_arr[axis_sel];
            SEL_BYTE0, SEL_BYTE1, SEL_BYTE2:
                       rd_byte = latch_arr[axis_sel][reg_sel[1:0]];
            default:   rd_byte = '0;
        endcase
    end

    assign dbus_oe  = ~cs_n & ~rd_n;
    assign dbus_out = dbus_oe ? rd_byte : '0;
endmodule

// File: tb/qc_host_regif_bench.sv
module qc_host_regif_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] reg_sel = '0;
    logic [1:0] axis_sel = '0;
    logic [7:0] dbus_in = '0;
    logic [7:0] dbus_out;
    logic dbus_oe;
    logic [31:0] axis_stat_i = '0;
    logic [95:0] axis_latch_i = '0;
    logic [3:0]  flag_a_n_i = '1;
    logic [31:0] mode0_o, mode1_o;
    logic [95:0] preset_o;
    logic [3:0] cnt_clear_o, cnt_load_o, latch_snap_o, stat_clear_o;
    logic [3:0] axis_reset_o, sign_set_o, sign_clear_o;
    logic irq_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    qc_host_regif u_qc_host_regif (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .reg_sel(reg_sel), .axis_sel(axis_sel), .dbus_in(dbus_in),
        .dbus_out(dbus_out), .dbus_oe(dbus_oe),
        .axis_stat_i(axis_stat_i), .axis_latch_i(axis_latch_i), .flag_a_n_i(flag_a_n_i),
        .mode0_o(mode0_o), .mode1_o(mode1_o), .preset_o(preset_o),
        .cnt_clear_o(cnt_clear_o), .cnt_load_o(cnt_load_o), .latch_snap_o(latch_snap_o),
        .stat_clear_o(stat_clear_o), .axis_reset_o(axis_reset_o),
        .sign_set_o(sign_set_o), .sign_clear_o(sign_clear_o), .irq_n(irq_n)
    );

    // reference model
    logic [7:0]  m_mode0 [NA];
    logic [7:0]  m_mode1 [NA];
    logic [23:0] m_preset [NA];
    logic [3:0]  m_mask, m_stat;
    int pc [7][NA];
    int n_cmp = 0, n_bad = 0;

    // pulse counters sampled away from the active edge
    always @(negedge clk) begin
        for (int a = 0; a < NA; a++) begin
            pc[0][a] += int'(cnt_clear_o[a]);
            pc[1][a] += int'(cnt_load_o[a]);
            pc[2][a] += int'(latch_snap_o[a]);
            pc[3][a] += int'(stat_clear_o[a]);
            pc[4][a] += int'(axis_reset_o[a]);
            pc[5][a] += int'(sign_set_o[a]);
            pc[6][a] += int'(sign_clear_o[a]);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_pc();
        for (int b = 0; b < 7; b++) for (int a = 0; a < NA; a++) pc[b][a] = 0;
    endtask

    function automatic logic [7:0] exp_read(input int a, input int sel);
        case (sel)
            0: return {m_stat, m_mask};
            1: return m_mode0[a];
            2: return m_mode1[a];
            3: return axis_stat_i[a*8 +: 8];
            4, 5, 6: return axis_latch_i[a*24 + (sel-4)*8 +: 8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input int a, input int sel, input logic [7:0] d);
        case (sel)
            0: m_mask = d[3:0];
            1: m_mode0[a] = d;
            2: m_mode1[a] = d;
            4, 5, 6: m_preset[a][(sel-4)*8 +: 8] = d;
            7: begin
                if (d[4]) begin
                    m_mode0[a] = '0; m_mode1[a] = '0; m_preset[a] = '0;
                    m_mask = '0; m_stat = '0;
                end
                if (d[7]) m_stat[a] = 1'b0;
            end
            default: ;
        endcase
    endtask

    task automatic check_state(input string req);
        for (int a = 0; a < NA; a++) begin
            chk({req, " mode0"}, 32'(mode0_o[a*8 +: 8]), 32'(m_mode0[a]));
            chk({req, " mode1"}, 32'(mode1_o[a*8 +: 8]), 32'(m_mode1[a]));
            chk({req, " preset"}, 32'(preset_o[a*24 +: 24]), 32'(m_preset[a]));
        end
        chk({req, " R12 irq_n"}, 32'(irq_n), 32'(m_stat == 4'h0));
    endtask

    task automatic check_pulses(input string req, input int a, input logic [7:0] d);
        for (int b = 0; b < 7; b++)
            for (int x = 0; x < NA; x++)
                chk(req, 32'(pc[b][x]), 32'((x == a && d[b]) ? 1 : 0));
    endtask

    task automatic bus_write(input int a, input int sel, input logic [7:0] d, input bit use_cs);
        @(negedge clk);
        cs_n = !use_cs; wr_n = 1'b0;
        reg_sel = 3'(sel); axis_sel = 2'(a); dbus_in = d;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (use_cs) model_write(a, sel, d);
    endtask

    task automatic bus_read(input int a, input int sel, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; reg_sel = 3'(sel); axis_sel = 2'(a);
        #1;
        d = dbus_out;
        chk("R2 oe during read", 32'(dbus_oe), 32'd1);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic set_flag(input int a, input logic v);
        @(negedge clk);
        if (flag_a_n_i[a] && !v && m_mask[a]) m_stat[a] = 1'b1;
        flag_a_n_i[a] = v;
        @(negedge clk);
    endtask

    task automatic run_all();
        logic [7:0] rd;
        for (int a = 0; a < NA; a++) begin m_mode0[a] = '0; m_mode1[a] = '0; m_preset[a] = '0; end
        m_mask = '0; m_stat = '0;
        repeat (3) @(negedge clk);
        clr_pc();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_state("R1");
        chk("R1 oe", 32'(dbus_oe), 32'd0);
        check_pulses("R1 no pulses", 0, 8'h00);

        // R2 bus drive enable
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
        chk("R2 cs high oe", 32'(dbus_oe), 32'd0);
        chk("R2 cs high data", 32'(dbus_out), 32'd0);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #1;
        chk("R2 rd high oe", 32'(dbus_oe), 32'd0);
        @(negedge clk); cs_n = 1'b1;

        // R6 mask write ignores upper nibble, R4 combined read
        bus_write(0, 0, 8'hA5, 1);
        bus_read(0, 0, rd);
        chk("R4 R6 irq byte", 32'(rd), 32'h05);

        // R7 write commit point
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; reg_sel = 3'd4; axis_sel = 2'd1; dbus_in = 8'h3C;
        repeat (2) @(negedge clk);
        chk("R7 still low", 32'(preset_o[24 +: 24]), 32'd0);
        wr_n = 1'b1;
        @(negedge clk); chk("R7 edge1", 32'(preset_o[24 +: 24]), 32'd0);
        @(negedge clk); chk("R7 edge2", 32'(preset_o[24 +: 24]), 32'd0);
        @(negedge clk); chk("R7 edge3", 32'(preset_o[24 +: 24]), 32'h3C);
        cs_n = 1'b1;
        @(negedge clk);
        m_preset[1][7:0] = 8'h3C;

        // R7 strobe without chip select
        bus_write(2, 1, 8'h77, 0);
        check_state("R7 no cs");

        // R5 write at select 3 is ignored
        bus_write(3, 3, 8'hFF, 1);
        check_state("R5 sel3");
        bus_read(3, 0, rd);
        chk("R5 sel3 irq byte", 32'(rd), 32'({m_stat, m_mask}));

        // R11 masked edge and unmasked edge
        set_flag(1, 1'b0);
        chk("R11 masked axis1", 32'(irq_n), 32'd1);
        set_flag(0, 1'b0);
        chk("R11 axis0 set", 32'(irq_n), 32'd0);
        bus_read(0, 0, rd);
        chk("R11 R4 status", 32'(rd), 32'h15);
        set_flag(0, 1'b1); set_flag(1, 1'b1);
        set_flag(2, 1'b0); set_flag(2, 1'b1);
        bus_read(0, 0, rd);
        chk("R11 sticky", 32'(rd), 32'h55);

        // R10 per-axis interrupt clear
        clr_pc();
        bus_write(2, 7, 8'h80, 1);
        bus_read(0, 0, rd);
        chk("R10 clear axis2", 32'(rd), 32'h15);
        check_pulses("R10 no other pulses", 2, 8'h00);
        bus_write(0, 7, 8'h80, 1);
        chk("R12 irq released", 32'(irq_n), 32'd1);

        // R9 axis master reset
        bus_write(0, 1, 8'h11, 1); bus_write(1, 2, 8'h22, 1);
        bus_write(0, 6, 8'h99, 1); bus_write(0, 0, 8'h0F, 1);
        set_flag(3, 1'b0); set_flag(3, 1'b1);
        clr_pc();
        bus_write(0, 7, 8'h10, 1);
        check_state("R9 axis reset");
        check_pulses("R9 R8 reset pulse", 0, 8'h10);
        bus_read(0, 0, rd);
        chk("R9 irq byte", 32'(rd), 32'h00);

        // R8 all pulse bits on axis 3
        clr_pc();
        bus_write(3, 7, 8'h6F, 1);
        check_pulses("R8 all bits", 3, 8'h6F);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op, a, sel;
            logic [7:0] d;
            op = int'($urandom_range(0, 8));
            a  = int'($urandom_range(0, 3));
            d  = 8'($urandom);
            if (op <= 2) begin
                sel = int'($urandom_range(0, 6));
                bus_write(a, sel, d, 1);
                check_state("R5 random write");
            end else if (op <= 5) begin
                sel = int'($urandom_range(0, 7));
                axis_stat_i  = $urandom;
                axis_latch_i = {$urandom, $urandom, $urandom};
                bus_read(a, sel, rd);
                chk("R3 R4 random read", 32'(rd), 32'(exp_read(a, sel)));
            end else if (op <= 7) begin
                set_flag(a, ~flag_a_n_i[a]);
                check_state("R11 random flag");
            end else begin
                if ($urandom_range(0, 7) != 0) d[4] = 1'b0;
                clr_pc();
                bus_write(a, 7, d, 1);
                check_pulses("R8 random cmd", a, d);
                check_state("R9 R10 random cmd");
            end
        end
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        void'($urandom(32'd5150));
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule